// File: doc/BRIEF.md
# Synchronous Clock Park Gate

This block sits at the end of a clock distribution path, after the phase and skew generator. It decides, bank by bank, whether the bank's clock waveform reaches its output pins or whether the pins are parked at a quiet level. Each bank waveform comes in as a level that is sampled on the block clock. Each bank drives a pair of identical outputs. A global disable request stops every bank except the feedback bank, which has to keep toggling so that the upstream loop stays locked. Starting and stopping happen only while the bank waveform sits at its parked level, so an output never emits a shortened pulse.

The parked level is set by the edge-polarity input: it is the inverse of that input. The three-valued bypass input changes two things. In any bypass state other than LOW, a LOW polarity input inverts the undivided bank waveforms, which turns a 20 % high input into an 80 % high output. In the MID bypass state combined with an active disable, the disable is applied per bank, according to each bank's select code.

Top module: `clk_park_gate`

## Requirements
- R1: While reset is held, and on the first clock after reset is released, every output sits at the parked level, which is the inverse of `edge_pol`. A bank starts to toggle only after its waveform has been seen at the parked level once.
- R2: When `out_dis_async` is 1 and `byp_mode` is not MID (00 = LOW, 01 = MID, 10 or 11 = HIGH), banks 0, 1 and 3 park. The feedback bank (index 2) keeps following its waveform.
- R3: An output enters the parked level only on the clock after its bank waveform was at the parked level. A parking output never cuts a pulse short.
- R4: A parked output holds 0 when `edge_pol` is 1 and holds 1 when `edge_pol` is 0. It stays there for as long as it is disabled.
- R5: After the disable is withdrawn, an output leaves the parked level only by copying a bank waveform that has just moved away from the parked level. It resumes on a cycle boundary.
- R6: With `out_dis_async` at 1 and `byp_mode` at MID, any bank whose 4-bit select field (`bank_sel[4b+3:4b]`, two digits of 2 bits each, 00 = LOW) is 0000 parks. All other banks, the feedback bank included, keep running.
- R7: With `byp_mode` not LOW and `edge_pol` at 0, each undivided bank output is the inverse of its waveform, so a 20 % high waveform gives an 80 % high output. With `edge_pol` at 1 the waveform passes unchanged.
- R8: The feedback bank counts as divided when its select field has both digits LOW (0000) or both digits HIGH (1x1x). A divided bank is never inverted, whatever the bypass and polarity inputs are.
- R9: `out_dis_async` passes through a two-stage synchroniser. A change on it cannot alter any output until the fourth rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bank waveforms and controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_dis_async | input | 1 | Global output-disable request, asynchronous to `clk` |
| edge_pol | input | 1 | Alignment polarity; the parked level is its inverse |
| byp_mode | input | 2 | Three-valued bypass mode: 00 LOW, 01 MID, 1x HIGH |
| bank_sel | input | 4*NUM_BANKS | Per-bank select code, two three-valued digits per bank |
| bank_clk | input | NUM_BANKS | Sampled bank clock waveforms from the skew generator |
| q_out | output | NUM_BANKS*OUTS_PER_BANK | Gated outputs, bank b on bits [2b+1:2b] |

## Verification
The four bank waveforms have different periods and duty cycles: 50 %, 20 %, a 25 % feedback waveform and a short-period one. Because of this, one output pattern cannot be mistaken for another bank's, and a missing or spurious inversion shows up as a wrong high count. A scoreboard compares every output bit on every cycle. It is run through global disable and re-enable under both polarities, which separates the feedback exemption and the parked level from plain gating. A check on the cycles right after re-enable separates the synchroniser latency from the boundary rule. A per-bank disable run in the MID bypass state separates the select decode from the global path. High-count windows with bypass at HIGH under both polarities, with the feedback bank set to divided, separate inversion of the undivided banks from the divided bank, which keeps its shape.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

  // Three-valued control digit, carried on two bits.
  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_HI_X = 2'b11
  } lvl3_e;

  function automatic logic lvl_is_low(input logic [1:0] v);
    return v == LVL_LOW;
  endfunction

  function automatic logic lvl_is_mid(input logic [1:0] v);
    return v == LVL_MID;
  endfunction

  function automatic logic lvl_is_high(input logic [1:0] v);
    return v[1];
  endfunction

  // Quiet level of a stopped output.
  function automatic logic park_of(input logic pol);
    return ~pol;
  endfunction

  function automatic logic sel_both_low(input logic [3:0] s);
    return lvl_is_low(s[3:2]) && lvl_is_low(s[1:0]);
  endfunction

  function automatic logic sel_divides(input logic [3:0] s);
    return sel_both_low(s) || (lvl_is_high(s[3:2]) && lvl_is_high(s[1:0]));
  endfunction

  // Whether a bank is asked to run, given the synchronised disable.
  function automatic logic bank_want(input logic dis, input logic [1:0] byp,
                                     input logic [3:0] s, input logic is_fb);
    if (!dis)            return 1'b1;
    if (lvl_is_mid(byp)) return !sel_both_low(s);
    return is_fb;
  endfunction

endpackage

// File: rtl/clk_park_sync.sv
module clk_park_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/clk_park_mode.sv
module clk_park_mode
  import clk_park_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int FB_BANK   = 2
) (
  input  logic                   dis_sync,
  input  logic                   edge_pol,
  input  logic [1:0]             byp_mode,
  input  logic [4*NUM_BANKS-1:0] bank_sel,
  output logic [NUM_BANKS-1:0]   want,
  output logic [NUM_BANKS-1:0]   invert,
  output logic [NUM_BANKS-1:0]   park
);
  logic byp_on;
  assign byp_on = !lvl_is_low(byp_mode);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic IS_FB = (b == FB_BANK);
    logic [3:0] sel_b;
    logic       divided;
    assign sel_b     = bank_sel[4*b +: 4];
    assign divided   = IS_FB && sel_divides(sel_b);
    assign invert[b] = byp_on && !edge_pol && !divided;
    assign want[b]   = bank_want(dis_sync, byp_mode, sel_b, IS_FB);
    assign park[b]   = park_of(edge_pol);
  end
endmodule

// File: rtl/clk_park_bank.sv
module clk_park_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic wave,
  input  logic park,
  input  logic want,
  output logic run,
  output logic q
);
  logic act;       // 1: output is away from the parked level
  logic at_park;   // waveform sits at the parked level: a safe boundary

  assign at_park = (wave == park);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      act <= 1'b0;
    end else begin
      if (at_park) run <= want;
      act <= run && !at_park;
    end
  end

  assign q = act ^ park;
endmodule

// File: rtl/clk_park_gate.sv
module clk_park_gate
  import clk_park_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int OUTS_PER_BANK = 2,
  parameter int FB_BANK       = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               out_dis_async,
  input  logic                               edge_pol,
  input  logic [1:0]                         byp_mode,
  input  logic [4*NUM_BANKS-1:0]             bank_sel,
  input  logic [NUM_BANKS-1:0]               bank_clk,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0] q_out
);
  localparam int OUT_W = NUM_BANKS * OUTS_PER_BANK;

  logic                 dis_sync;
  logic [NUM_BANKS-1:0] want, invert, park, wave, run, q_bank;

  clk_park_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(out_dis_async), .q(dis_sync)
  );

  clk_park_mode #(.NUM_BANKS(NUM_BANKS), .FB_BANK(FB_BANK)) u_mode (
    .dis_sync(dis_sync), .edge_pol(edge_pol), .byp_mode(byp_mode),
    .bank_sel(bank_sel), .want(want), .invert(invert), .park(park)
  );

  assign wave = bank_clk ^ invert;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gate
    clk_park_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wave(wave[b]), .park(park[b]),
      .want(want[b]), .run(run[b]), .q(q_bank[b])
    );
  end

  for (genvar o = 0; o < OUT_W; o++) begin : g_fan
    assign q_out[o] = q_bank[o / OUTS_PER_BANK];
  end
endmodule

// File: rtl/clk_park_gate_chk.sv
module clk_park_gate_chk
  import clk_park_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int FB_BANK   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   edge_pol,
  input logic [1:0]             byp_mode,
  input logic [4*NUM_BANKS-1:0] bank_sel,
  input logic                   dis_sync,
  input logic [NUM_BANKS-1:0]   wave,
  input logic [NUM_BANKS-1:0]   park,
  input logic [NUM_BANKS-1:0]   run,
  input logic [NUM_BANKS-1:0]   q_bank
);
  p_fb_keeps_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_is_mid(byp_mode) && run[FB_BANK]) |=> run[FB_BANK]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_park_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(edge_pol) && q_bank[b] == park[b] && $past(q_bank[b]) != park[b])
        |-> $past(wave[b]) == park[b]);

    p_parked_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(edge_pol) && !$past(run[b]) && !$past(run[b], 2))
        |-> q_bank[b] == ~edge_pol);

    p_resume_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(edge_pol) && q_bank[b] != park[b] && $past(q_bank[b]) == park[b])
        |-> $past(wave[b]) != park[b]);

    p_bank_select_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_sync && lvl_is_mid(byp_mode) && sel_both_low(bank_sel[4*b +: 4])
        && wave[b] == park[b]) |=> !run[b]);
  end
endmodule

bind clk_park_gate clk_park_gate_chk #(.NUM_BANKS(NUM_BANKS), .FB_BANK(FB_BANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_pol(edge_pol), .byp_mode(byp_mode),
  .bank_sel(bank_sel), .dis_sync(dis_sync), .wave(wave), .park(park),
  .run(run), .q_bank(q_bank)
);

// File: tb/tb_clk_park_gate.sv
module tb_clk_park_gate;
  localparam int NB = 4;
  localparam int NO = 2;
  localparam int FB = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic           rst_n = 1'b0;
  logic           out_dis = 1'b0;
  logic           edge_pol = 1'b1;
  logic [1:0]     byp = 2'b00;
  logic [4*NB-1:0] sel = {NB{4'b0101}};
  logic [NB-1:0]  bclk = '0;
  wire  [NB*NO-1:0] q;

  clk_park_gate #(.NUM_BANKS(NB), .OUTS_PER_BANK(NO), .FB_BANK(FB)) dut (
    .clk(clk), .rst_n(rst_n), .out_dis_async(out_dis), .edge_pol(edge_pol),
    .byp_mode(byp), .bank_sel(sel), .bank_clk(bclk), .q_out(q)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Bank waveforms: periods and high times differ per bank.
  int per [NB] = '{8, 10, 16, 6};
  int hi  [NB] = '{4, 2, 4, 3};
  int ph  [NB] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    for (int b = 0; b < NB; b++) begin
      ph[b] = (ph[b] + 1) % per[b];
      bclk[b] <= (ph[b] < hi[b]);
    end
  end

  // Reference model: produces the expected output word for each edge.
  logic [NB*NO-1:0] exp_q [$];
  logic m_s1, m_s2;
  logic [NB-1:0] m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1'b0; m_s2 = 1'b0; m_run = '0;
      exp_q.delete();
    end else begin
      logic [NB*NO-1:0] e;
      for (int b = 0; b < NB; b++) begin
        logic [3:0] sb;
        logic quiet, div, flip, w, go, ov;
        sb    = sel[4*b +: 4];
        quiet = !edge_pol;
        div   = (b == FB) && (sb == 4'b0000 || (sb[3] && sb[1]));
        flip  = (byp != 2'b00) && !edge_pol && !div;
        w     = bclk[b] ^ flip;
        if (!m_s2)              go = 1'b1;
        else if (byp == 2'b01)  go = (sb != 4'b0000);
        else                    go = (b == FB);
        ov = m_run[b] ? w : quiet;
        for (int o = 0; o < NO; o++) e[b*NO+o] = ov;
        if (w == quiet) m_run[b] = go;
      end
      m_s2 = m_s1;
      m_s1 = out_dis;
      exp_q.push_back(e);
    end
  end

  // Monitor: pops one expected word per cycle and compares.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [NB*NO-1:0] e;
      e = exp_q.pop_front();
      n_cmp++;
      if (q !== e) begin
        n_bad++;
        $display("FAIL %s scoreboard: q=%b expected %b", tag, q, e);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  // Count highs and toggles of one bank's first output over n cycles.
  task automatic watch(input int n, input int bank, output int highs, output int togs);
    logic prev;
    highs = 0; togs = 0;
    @(negedge clk); #2; prev = q[bank*NO];
    repeat (n) begin
      @(negedge clk); #2;
      if (q[bank*NO]) highs++;
      if (q[bank*NO] != prev) togs++;
      if (q[bank*NO] != q[bank*NO+1]) begin
        n_bad++; $display("FAIL R2 pair mismatch bank %0d: %b vs %b", bank, q[bank*NO], q[bank*NO+1]);
      end
      prev = q[bank*NO];
    end
  endtask

  task automatic do_reset(input bit pol);
    @(negedge clk); #1;
    rst_n = 1'b0; edge_pol = pol;
    tick(3);
    check(q == {NB*NO{~pol}}, "R1 reset park", q, {NB*NO{~pol}});
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #2;
    check(q == {NB*NO{~pol}}, "R1 first cycle parked", q, {NB*NO{~pol}});
  endtask

  initial begin
    int h, t;
    // Phase 1: normal running, rising alignment.
    tag = "R1";
    do_reset(1'b1);
    tag = "R5"; tick(60);

    // Phase 2: global disable, polarity 1.
    tag = "R2 R3 R4"; out_dis = 1'b1; tick(30);
    watch(40, 0, h, t); check(h == 0, "R4 bank0 parked low", h, 0);
    watch(40, 1, h, t); check(h == 0, "R2 bank1 parked", h, 0);
    watch(40, 3, h, t); check(h == 0, "R2 bank3 parked", h, 0);
    watch(40, FB, h, t); check(t > 0, "R2 feedback bank runs", t, 1);

    // Phase 3: re-enable; synchroniser latency then resume.
    tag = "R5 R9"; out_dis = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      check(q[0] == 1'b0, "R9 still parked during sync", q[0], 0);
    end
    tick(30);
    watch(40, 0, h, t); check(t > 0, "R5 bank0 resumed", t, 1);

    // Phase 4: falling alignment, disable parks high.
    tag = "R4";
    do_reset(1'b0);
    tick(20);
    out_dis = 1'b1; tag = "R2 R4"; tick(30);
    watch(40, 0, h, t); check(h == 40, "R4 bank0 parked high", h, 40);
    watch(40, FB, h, t); check(t > 0, "R2 feedback runs pol0", t, 1);

    // Phase 5: per-bank disable in MID bypass.
    tag = "R6"; byp = 2'b01; sel[3:0] = 4'b0000; tick(30);
    watch(40, 0, h, t); check(h == 40, "R6 selected bank parked", h, 40);
    watch(40, 1, h, t); check(t > 0, "R6 other bank runs", t, 1);
    watch(40, 3, h, t); check(t > 0, "R6 bank3 runs", t, 1);

    // Phase 6: HIGH bypass, polarity 0, feedback bank divided.
    tag = "R7 R8"; out_dis = 1'b0; byp = 2'b10;
    sel = {4'b0101, 4'b0000, 4'b0101, 4'b0101}; tick(40);
    watch(80, 1, h, t); check(h == 64, "R7 inverted 20pct to 80pct", h, 64);
    watch(80, FB, h, t); check(h == 20, "R8 divided not inverted", h, 20);
    sel[4*FB +: 4] = 4'b1010; tick(30);
    watch(80, FB, h, t); check(h == 20, "R8 both-high divided not inverted", h, 20);

    // Phase 7: HIGH bypass, polarity 1: no inversion.
    tag = "R7"; do_reset(1'b1); tick(30);
    watch(80, 1, h, t); check(h == 16, "R7 pol1 keeps duty", h, 16);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule